// File: doc/BRIEF.md
# Critical-Word-First Line Fill Engine

This block services one cache miss at a time for a cache whose lines hold several words. When a miss is accepted it issues one line request to the next memory level. The request carries the missing word's address, and the next level returns the line one word per beat. The returned words start at that word and wrap around the end of the line. The very first beat is the word the processor is stalled on. The engine hands that beat straight back to the requester with a one-cycle restart pulse, so the processor resumes without waiting for the rest of the line.

The remaining beats are written into an internal line buffer and passed out to the data array while the processor runs. A small probe port lets the surrounding cache ask whether a word of the line being filled has already arrived. The probe returns that word from the line buffer, and only for words already written. The line's tag and valid bit are released to the tag array in a single commit cycle after the final beat. The engine stays busy from the accepted miss through that commit cycle. While it is busy it refuses further misses, so fills never overlap. Tag comparison and victim choice belong to the surrounding cache and are not part of this block.

Top module: `cwf_fill_unit`

## Requirements
- R1: While reset is held and in the first cycle after it is released, fillBusy, memReqValid, cpuValid, arrWrEn, tagWrEn and probeHit are 0, and missReady is 1.
- R2: A miss accepted at a clock edge (missValid and missReady both high) raises memReqValid in the following cycle. memReqAddr then equals the miss address with its two byte-offset bits cleared. Both signals hold steady until memReqReady is seen high at a clock edge.
- R3: The address is split, from the least significant bit upward, into byte offset [1:0], word-in-line [4:2], set index [10:5] and tag [31:11]. Beat k of a fill writes word (critical word + k) mod 8 of the captured set with the beat's data. That write is shown on arrWrEn/arrWrSet/arrWrWord/arrWrData in the same cycle that memRspValid presents the beat.
- R4: In the cycle after the first beat, cpuValid is 1 for exactly one cycle and cpuData carries that beat's data. cpuValid stays 0 for every later beat of the same fill.
- R5: tagWrEn is 1 for exactly one cycle, the cycle after the last beat, with tagWrSet and tagWrTag taken from the miss address. It is 0 at all other times during a fill.
- R6: fillBusy is 1 from the cycle after a miss is accepted through the commit cycle, and missReady is its inverse. A miss request held high while the engine is busy issues no new line request, and it is not accepted if it is withdrawn before the engine returns to idle.
- R7: probeHit is 1 only while a fill is in progress, only for a probe address with the same tag and set as the line being filled, and only for a word already written. probeData then equals that word. After the commit cycle, probeHit is 0.
- R8: memRspValid is ignored (arrWrEn stays 0) when the engine is idle or is still waiting for its request to be taken.
- R9: The engine counts received beats and finishes a fill after exactly 8 beats, however many idle cycles separate the beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | A miss is waiting to be serviced |
| missAddr | input | 32 | Byte address of the missing word |
| missReady | output | 1 | Engine can accept a miss this cycle |
| memReqValid | output | 1 | Line request to the next level |
| memReqAddr | output | 32 | Word-aligned address of the critical word |
| memReqReady | input | 1 | Next level takes the request |
| memRspValid | input | 1 | One beat of line data is present |
| memRspData | input | 32 | Beat data, in wrap order from the critical word |
| cpuValid | output | 1 | Early-restart pulse for the requester |
| cpuData | output | 32 | Critical word for the requester |
| arrWrEn | output | 1 | Data array word write strobe |
| arrWrSet | output | 6 | Data array set to write |
| arrWrWord | output | 3 | Word position within the line |
| arrWrData | output | 32 | Word to write |
| tagWrEn | output | 1 | Tag and valid commit strobe |
| tagWrSet | output | 6 | Set whose tag is committed |
| tagWrTag | output | 21 | Tag value to commit |
| fillBusy | output | 1 | A fill is in progress |
| probeAddr | input | 32 | Address looked up in the fill line buffer |
| probeHit | output | 1 | Probed word already arrived in the current fill |
| probeData | output | 32 | Probed word from the line buffer |

## Verification
The bench aims at critical words at the first position, in the middle and at the last position of the line. A design that fails to wrap would write past word 7 or drop the words below the critical one. A design that counted from zero would fill the wrong positions, and the scoreboard of array writes catches both. Fills with idle gaps between beats check that the restart pulse fires only once and that the tag commits after the eighth beat rather than a fixed number of cycles after the request. Probes during a fill, to an arrived word, a missing word and a foreign line, expose a buffer that answers too early. A miss held high through a fill, and stray response beats presented while idle or before the request is taken, show whether the engine overlaps fills or writes data that belongs to no fill.

// File: rtl/cwf_fill_pkg.sv
package cwf_fill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_FILL,
    ST_COMMIT
  } fill_state_t;

  // strobes the controller hands to the datapath each cycle
  typedef struct packed {
    logic capture;    // latch miss address, clear written mask
    logic beat;       // a response beat is being written
    logic firstBeat;  // this beat is the critical word
    logic commit;     // publish tag and valid
  } fill_strobe_t;

endpackage

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl
  import cwf_fill_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  parameter int OFF_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             missValid,
  input  logic             memReqReady,
  input  logic             memRspValid,
  output logic             fillBusy,
  output logic             missReady,
  output logic             memReqValid,
  output fill_strobe_t     strobes,
  output logic [OFF_W-1:0] beatIdx
);

  localparam logic [OFF_W-1:0] LastBeat = OFF_W'(LINE_WORDS - 1);

  fill_state_t state, stateNext;
  logic        accept;
  logic        beatNow;
  logic        lastNow;

  assign accept  = missValid && (state == ST_IDLE);
  assign beatNow = memRspValid && (state == ST_FILL);
  assign lastNow = beatNow && (beatIdx == LastBeat);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (accept)      stateNext = ST_REQ;
      ST_REQ:    if (memReqReady) stateNext = ST_FILL;
      ST_FILL:   if (lastNow)     stateNext = ST_COMMIT;
      ST_COMMIT:                  stateNext = ST_IDLE;
      default:                    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  // received-beat counter: doubles as the wrap offset from the critical word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatIdx <= '0;
    end else if (accept) begin
      beatIdx <= '0;
    end else if (beatNow) begin
      beatIdx <= beatIdx + 1'b1;
    end
  end

  always_comb begin
    strobes.capture   = accept;
    strobes.beat      = beatNow;
    strobes.firstBeat = beatNow && (beatIdx == '0);
    strobes.commit    = (state == ST_COMMIT);
  end

  assign fillBusy    = (state != ST_IDLE);
  assign missReady   = (state == ST_IDLE);
  assign memReqValid = (state == ST_REQ);

endmodule

// File: rtl/cwf_fill_datapath.sv
module cwf_fill_datapath
  import cwf_fill_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int OFF_W      = 3,
  parameter int IDX_W      = 6,
  parameter int TAG_W      = 21,
  parameter int BYTE_OFF   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  fill_strobe_t      strobes,
  input  logic [OFF_W-1:0]  beatIdx,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic [WORD_W-1:0] memRspData,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              cpuValid,
  output logic [WORD_W-1:0] cpuData,
  output logic              arrWrEn,
  output logic [IDX_W-1:0]  arrWrSet,
  output logic [OFF_W-1:0]  arrWrWord,
  output logic [WORD_W-1:0] arrWrData,
  output logic              tagWrEn,
  output logic [IDX_W-1:0]  tagWrSet,
  output logic [TAG_W-1:0]  tagWrTag,
  output logic              probeHit,
  output logic [WORD_W-1:0] probeData
);

  localparam int OffLo = BYTE_OFF;
  localparam int IdxLo = BYTE_OFF + OFF_W;
  localparam int TagLo = BYTE_OFF + OFF_W + IDX_W;

  logic [TAG_W-1:0]  tagQ;
  logic [IDX_W-1:0]  setQ;
  logic [OFF_W-1:0]  critQ;
  logic              lineOpen;
  logic [LINE_WORDS-1:0] writtenMask;
  logic [WORD_W-1:0] lineBuf [LINE_WORDS];
  logic [OFF_W-1:0]  wrWord;

  // captured miss address fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagQ  <= '0;
      setQ  <= '0;
      critQ <= '0;
    end else if (strobes.capture) begin
      tagQ  <= missAddr[ADDR_W-1:TagLo];
      setQ  <= missAddr[TagLo-1:IdxLo];
      critQ <= missAddr[IdxLo-1:OffLo];
    end
  end

  // a line is open for probing from capture until the commit cycle ends
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineOpen <= 1'b0;
    end else if (strobes.capture) begin
      lineOpen <= 1'b1;
    end else if (strobes.commit) begin
      lineOpen <= 1'b0;
    end
  end

  // wrap-around word position: modulo the line length by truncation
  assign wrWord = critQ + beatIdx;

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    logic hitHere;
    assign hitHere = strobes.beat && (wrWord == OFF_W'(w));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        writtenMask[w] <= 1'b0;
      end else if (strobes.capture) begin
        writtenMask[w] <= 1'b0;
      end else if (hitHere) begin
        writtenMask[w] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hitHere) begin
        lineBuf[w] <= memRspData;
      end
    end
  end

  // early restart: critical word goes back to the requester one cycle later
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuValid <= 1'b0;
      cpuData  <= '0;
    end else begin
      cpuValid <= strobes.firstBeat;
      if (strobes.firstBeat) begin
        cpuData <= memRspData;
      end
    end
  end

  assign memReqAddr = {tagQ, setQ, critQ, {BYTE_OFF{1'b0}}};

  assign arrWrEn   = strobes.beat;
  assign arrWrSet  = setQ;
  assign arrWrWord = wrWord;
  assign arrWrData = memRspData;

  assign tagWrEn  = strobes.commit;
  assign tagWrSet = setQ;
  assign tagWrTag = tagQ;

  // probe against the line under construction
  logic [TAG_W-1:0] pTag;
  logic [IDX_W-1:0] pSet;
  logic [OFF_W-1:0] pWord;

  assign pTag  = probeAddr[ADDR_W-1:TagLo];
  assign pSet  = probeAddr[TagLo-1:IdxLo];
  assign pWord = probeAddr[IdxLo-1:OffLo];

  assign probeHit  = lineOpen && (pTag == tagQ) && (pSet == setQ) && writtenMask[pWord];
  assign probeData = lineBuf[pWord];

endmodule

// File: rtl/cwf_fill_unit.sv
module cwf_fill_unit
  import cwf_fill_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int SETS       = 64,
  localparam int BYTE_OFF  = $clog2(WORD_W / 8),
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W - BYTE_OFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  output logic              missReady,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [WORD_W-1:0] memRspData,
  output logic              cpuValid,
  output logic [WORD_W-1:0] cpuData,
  output logic              arrWrEn,
  output logic [IDX_W-1:0]  arrWrSet,
  output logic [OFF_W-1:0]  arrWrWord,
  output logic [WORD_W-1:0] arrWrData,
  output logic              tagWrEn,
  output logic [IDX_W-1:0]  tagWrSet,
  output logic [TAG_W-1:0]  tagWrTag,
  output logic              fillBusy,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              probeHit,
  output logic [WORD_W-1:0] probeData
);

  fill_strobe_t     strobes;
  logic [OFF_W-1:0] beatIdx;

  cwf_fill_ctrl #(
    .LINE_WORDS(LINE_WORDS),
    .OFF_W     (OFF_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .missValid  (missValid),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .fillBusy   (fillBusy),
    .missReady  (missReady),
    .memReqValid(memReqValid),
    .strobes    (strobes),
    .beatIdx    (beatIdx)
  );

  cwf_fill_datapath #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .LINE_WORDS(LINE_WORDS),
    .OFF_W     (OFF_W),
    .IDX_W     (IDX_W),
    .TAG_W     (TAG_W),
    .BYTE_OFF  (BYTE_OFF)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .beatIdx   (beatIdx),
    .missAddr  (missAddr),
    .memRspData(memRspData),
    .probeAddr (probeAddr),
    .memReqAddr(memReqAddr),
    .cpuValid  (cpuValid),
    .cpuData   (cpuData),
    .arrWrEn   (arrWrEn),
    .arrWrSet  (arrWrSet),
    .arrWrWord (arrWrWord),
    .arrWrData (arrWrData),
    .tagWrEn   (tagWrEn),
    .tagWrSet  (tagWrSet),
    .tagWrTag  (tagWrTag),
    .probeHit  (probeHit),
    .probeData (probeData)
  );

endmodule

// File: rtl/cwf_fill_checker.sv
module cwf_fill_checker #(
  parameter int LINE_WORDS = 8
) (
  input logic clk,
  input logic rstN,
  input logic missValid,
  input logic missReady,
  input logic memReqValid,
  input logic memReqReady,
  input logic cpuValid,
  input logic arrWrEn,
  input logic tagWrEn,
  input logic fillBusy,
  input logic probeHit
);

  int beatsSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatsSeen <= 0;
    end else if (tagWrEn) begin
      beatsSeen <= 0;
    end else if (arrWrEn) begin
      beatsSeen <= beatsSeen + 1;
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!fillBusy && !memReqValid && !tagWrEn));

  p_req_from_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReqValid) |-> $past(missValid && missReady));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);

  p_restart_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |=> !cpuValid);

  p_restart_after_beat_r4: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |-> $past(arrWrEn));

  p_commit_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    tagWrEn |=> (!tagWrEn && !fillBusy));

  p_commit_after_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    tagWrEn |-> $past(arrWrEn));

  p_no_req_while_filling_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fillBusy && !memReqValid) |=> !$rose(memReqValid));

  p_probe_only_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    probeHit |-> fillBusy);

  p_write_only_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> (fillBusy && !memReqValid));

  p_beat_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    tagWrEn |-> (beatsSeen == LINE_WORDS));

endmodule

bind cwf_fill_unit cwf_fill_checker #(.LINE_WORDS(LINE_WORDS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .missValid  (missValid),
  .missReady  (missReady),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .cpuValid   (cpuValid),
  .arrWrEn    (arrWrEn),
  .tagWrEn    (tagWrEn),
  .fillBusy   (fillBusy),
  .probeHit   (probeHit)
);

// File: tb/sim_cwf_fill_unit.sv
module sim_cwf_fill_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic        missReady;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memReqReady = 1'b0;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        cpuValid;
  logic [31:0] cpuData;
  logic        arrWrEn;
  logic [5:0]  arrWrSet;
  logic [2:0]  arrWrWord;
  logic [31:0] arrWrData;
  logic        tagWrEn;
  logic [5:0]  tagWrSet;
  logic [20:0] tagWrTag;
  logic        fillBusy;
  logic [31:0] probeAddr = '0;
  logic        probeHit;
  logic [31:0] probeData;

  always #5 clk = ~clk;

  cwf_fill_unit u0 (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .missReady(missReady), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspData(memRspData),
    .cpuValid(cpuValid), .cpuData(cpuData), .arrWrEn(arrWrEn), .arrWrSet(arrWrSet),
    .arrWrWord(arrWrWord), .arrWrData(arrWrData), .tagWrEn(tagWrEn),
    .tagWrSet(tagWrSet), .tagWrTag(tagWrTag), .fillBusy(fillBusy),
    .probeAddr(probeAddr), .probeHit(probeHit), .probeData(probeData)
  );

  typedef struct {
    logic [5:0]  set;
    logic [2:0]  word;
    logic [31:0] data;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // next-level memory contents, computed from the word address
  function automatic logic [31:0] memWord(input logic [29:0] wa);
    return ({wa, 2'b00} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // monitor: every array write must match the next expected one (R3, R8)
  always @(negedge clk) begin
    if (rstN && arrWrEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected array write", {55'd0, arrWrWord, arrWrSet}, 64'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(arrWrSet === e.set && arrWrWord === e.word && arrWrData === e.data,
              "R3 array write",
              {23'd0, arrWrSet, arrWrWord, arrWrData},
              {23'd0, e.set, e.word, e.data});
      end
    end
  end

  task automatic stepEdge();
    @(posedge clk);
    #1;
  endtask

  task automatic doFill(input logic [31:0] addr, input int gap, input bit doProbe,
                        input bit stray, input bit holdOther);
    logic [2:0]  crit;
    logic [5:0]  setI;
    logic [20:0] tagI;
    crit = addr[4:2];
    setI = addr[10:5];
    tagI = addr[31:11];
    while (!missReady) stepEdge();
    missValid = 1'b1;
    missAddr  = addr;
    stepEdge();
    missValid = 1'b0;
    if (holdOther) begin
      missValid = 1'b1;
      missAddr  = addr ^ 32'h0000_1000;
    end
    check(memReqValid === 1'b1, "R2 request raised", {63'd0, memReqValid}, 64'd1);
    check(memReqAddr === {addr[31:2], 2'b00}, "R2 request address", {32'd0, memReqAddr},
          {32'd0, addr[31:2], 2'b00});
    check(fillBusy === 1'b1 && missReady === 1'b0, "R6 busy after accept",
          {62'd0, fillBusy, missReady}, 64'd2);
    if (stray) begin
      memRspValid = 1'b1;
      memRspData  = 32'hDEAD_BEEF;
      #2;
      check(arrWrEn === 1'b0, "R8 beat before request taken", {63'd0, arrWrEn}, 64'd0);
      memRspValid = 1'b0;
    end
    // hold the request one extra cycle without ready
    stepEdge();
    check(memReqValid === 1'b1 && memReqAddr === {addr[31:2], 2'b00}, "R2 request held",
          {31'd0, memReqValid, memReqAddr}, {31'd0, 1'b1, addr[31:2], 2'b00});
    memReqReady = 1'b1;
    stepEdge();
    memReqReady = 1'b0;
    for (int k = 0; k < 8; k++) begin
      logic [2:0]  w;
      logic [31:0] d;
      w = crit + 3'(k);
      d = memWord({tagI, setI, w});
      expQ.push_back('{set: setI, word: w, data: d});
      memRspValid = 1'b1;
      memRspData  = d;
      stepEdge();
      memRspValid = 1'b0;
      if (k == 0) begin
        check(cpuValid === 1'b1 && cpuData === d, "R4 early restart",
              {31'd0, cpuValid, cpuData}, {31'd0, 1'b1, d});
      end else begin
        check(cpuValid === 1'b0, "R4 no second restart", {63'd0, cpuValid}, 64'd0);
      end
      if (k < 7) begin
        check(tagWrEn === 1'b0 && fillBusy === 1'b1, "R5 no early commit",
              {62'd0, tagWrEn, fillBusy}, 64'd1);
        if (holdOther) begin
          check(memReqValid === 1'b0, "R6 miss held off while busy", {63'd0, memReqValid}, 64'd0);
        end
      end
      if (doProbe && k == 2) begin
        logic [2:0] w1;
        logic [2:0] w5;
        w1 = crit + 3'd1;
        w5 = crit + 3'd5;
        probeAddr = {tagI, setI, w1, 2'b00};
        #1;
        check(probeHit === 1'b1 && probeData === memWord({tagI, setI, w1}), "R7 probe arrived word",
              {31'd0, probeHit, probeData}, {31'd0, 1'b1, memWord({tagI, setI, w1})});
        probeAddr = {tagI, setI, w5, 2'b00};
        #1;
        check(probeHit === 1'b0, "R7 probe missing word", {63'd0, probeHit}, 64'd0);
        probeAddr = {tagI ^ 21'h1, setI, w1, 2'b00};
        #1;
        check(probeHit === 1'b0, "R7 probe other line", {63'd0, probeHit}, 64'd0);
        probeAddr = {tagI, setI, crit, 2'b00};
      end
      if (k < 7) begin
        for (int g = 0; g < gap; g++) stepEdge();
      end
    end
    check(tagWrEn === 1'b1 && tagWrSet === setI && tagWrTag === tagI, "R5 commit",
          {36'd0, tagWrEn, tagWrSet, tagWrTag}, {36'd0, 1'b1, setI, tagI});
    check(fillBusy === 1'b1, "R9 busy through commit", {63'd0, fillBusy}, 64'd1);
    stepEdge();
    check(fillBusy === 1'b0 && missReady === 1'b1 && tagWrEn === 1'b0, "R9 fill done after 8 beats",
          {61'd0, fillBusy, missReady, tagWrEn}, 64'd2);
    if (doProbe) begin
      check(probeHit === 1'b0, "R7 no probe hit after commit", {63'd0, probeHit}, 64'd0);
    end
    if (holdOther) begin
      missValid = 1'b0;
      stepEdge();
      check(memReqValid === 1'b0 && fillBusy === 1'b0, "R6 withdrawn miss not taken",
            {62'd0, memReqValid, fillBusy}, 64'd0);
    end
    check(expQ.size() == 0, "R3 all beats written", 64'(expQ.size()), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(fillBusy === 1'b0 && missReady === 1'b1 && memReqValid === 1'b0 &&
          cpuValid === 1'b0 && arrWrEn === 1'b0 && tagWrEn === 1'b0 && probeHit === 1'b0,
          "R1 reset outputs", {57'd0, fillBusy, missReady, memReqValid, cpuValid, arrWrEn, tagWrEn, probeHit},
          64'h20);
    rstN = 1'b1;
    stepEdge();
    check(fillBusy === 1'b0 && missReady === 1'b1 && tagWrEn === 1'b0, "R1 idle after reset",
          {61'd0, fillBusy, missReady, tagWrEn}, 64'd2);
    // stray beat while idle
    memRspValid = 1'b1;
    memRspData  = 32'h1234_5678;
    #2;
    check(arrWrEn === 1'b0, "R8 idle beat ignored", {63'd0, arrWrEn}, 64'd0);
    stepEdge();
    memRspValid = 1'b0;
    check(fillBusy === 1'b0, "R8 idle beat starts nothing", {63'd0, fillBusy}, 64'd0);

    doFill(32'h000C_14B8, 0, 1'b0, 1'b0, 1'b0);  // critical word 6
    doFill(32'h0001_2340, 0, 1'b0, 1'b1, 1'b0);  // critical word 0, stray beat
    doFill(32'hABCD_E7FC, 2, 1'b1, 1'b0, 1'b0);  // critical word 7, gaps, probe
    doFill(32'h7654_3A90, 3, 1'b1, 1'b0, 1'b1);  // mid word, held-off second miss
    doFill(32'h7654_3A84, 0, 1'b0, 1'b0, 1'b0);  // same set, back-to-back
    repeat (3) stepEdge();
    check(expQ.size() == 0, "R8 no trailing writes", 64'(expQ.size()), 64'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule